// File: doc/BRIEF.md
# Amplitude Scaler with Dither Injection

This block sits in a direct digital synthesis datapath, after the waveform lookup table and before the digital-to-analog converter. Each valid amplitude sample is multiplied by a programmable amplitude word, which provides digital amplitude modulation. The block then reduces the result to the narrower converter width.

An optional pseudo-random dither of up to about half an output LSB can be added before the width reduction. This turns the quantization error from a signal-correlated spur pattern into noise. When the synthesis frequency ratio is already chosen well, the dither can be switched off.

The dither source is a maximal-length shift register. It steps once for every accepted sample. The dithered sum is clipped at the signed full-scale limits, so it never wraps. The output is a signed two's-complement code with a valid strobe, two clock cycles after the input.

Top module: `amp_dither_scaler`

## Requirements
- R1: `out_valid` rises exactly two rising clock edges after an edge that samples `in_valid` high, and it is low in every other cycle. Synchronous reset clears `out_valid` and `out_code` to 0.
- R2: With dither disabled, the output is computed in two steps, both using floor (arithmetic shift):
  - first `s = floor(sample * amp / 2^AMP_W)`, where the sample is signed and the amplitude word is unsigned;
  - then `out_code = floor(s / 2^(IN_W-OUT_W))`.
- R3: An amplitude word of all ones passes the sample at a gain of (2^AMP_W-1)/2^AMP_W, so the result is within one output LSB of the sample reduced to output width.
- R4: An amplitude word of zero gives `out_code` 0 (signed mid-scale), with dither either enabled or disabled.
- R5: With dither enabled, the dither value `d` is the low IN_W-OUT_W-1 bits of the shift register state, read as an unsigned number, and it is added to `s` before the floor. `d` is at most half an output LSB.
- R6: The dither register has these properties:
  - it is a right-shifting Galois register with feedback mask `TAPS` (default 16'hB400);
  - reset loads it with `SEED` (default 16'hACE1);
  - it advances once per accepted sample, whether dither is enabled or not, and holds otherwise;
  - sample n after reset uses the state reached after n advances.
- R7: The dithered sum saturates at 2^(IN_W-1)-1. A maximum positive sample at all-ones gain gives the largest positive code, and never a wrapped negative code.
- R8: The most negative sample at all-ones gain gives the most negative code (-2^(OUT_W-1)).
- R9: The amplitude word and the dither enable are captured together with the sample. Changes to them while `in_valid` is low do not alter a result that is already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | IN_W | Signed table amplitude |
| amp_word | input | AMP_W | Unsigned amplitude (gain) word |
| dither_en | input | 1 | Enables dither addition |
| out_valid | output | 1 | Output code strobe |
| out_code | output | OUT_W | Signed converter code |

## Verification
Every result is due two rising edges after the edge that takes in the sample. The bench drives inputs on the falling edge and reads outputs on the falling edge that follows the second rising edge. In single-sample scenarios it also checks that `out_valid` is still low one cycle after the stimulus. In streaming scenarios each output is compared at the falling edge two positions after its sample was driven, while an independent model of the dither register advances once per driven sample.

// File: rtl/amp_dither_pkg.sv
package amp_dither_pkg;
  localparam int unsigned DEF_IN_W   = 16;
  localparam int unsigned DEF_AMP_W  = 16;
  localparam int unsigned DEF_OUT_W  = 12;
  localparam int unsigned DEF_LFSR_W = 16;
  localparam logic [15:0] DEF_TAPS   = 16'hB400;
  localparam logic [15:0] DEF_SEED   = 16'hACE1;
endpackage

// File: rtl/ad_lfsr.sv
module ad_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/ad_mul_stage.sv
module ad_mul_stage #(
  parameter int unsigned IN_W = 16,
  parameter int unsigned AMP_W = 16,
  parameter int unsigned DITH_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_i,
  input  logic signed [IN_W-1:0] sample_i,
  input  logic [AMP_W-1:0]       amp_i,
  input  logic [DITH_W-1:0]      dith_i,
  input  logic                   den_i,
  output logic                   vld_o,
  output logic signed [IN_W-1:0] scaled_o,
  output logic [DITH_W-1:0]      dith_o
);
  localparam int unsigned PW = IN_W + AMP_W + 1;

  logic signed [PW-1:0] a_ext, b_ext, prod;

  assign a_ext = $signed({{(AMP_W+1){sample_i[IN_W-1]}}, sample_i});
  assign b_ext = $signed({{(IN_W+1){1'b0}}, amp_i});
  assign prod  = a_ext * b_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o    <= 1'b0;
      scaled_o <= '0;
      dith_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        scaled_o <= prod[AMP_W +: IN_W];
        dith_o   <= den_i ? dith_i : '0;
      end
    end
  end
endmodule

// File: rtl/ad_quant_stage.sv
module ad_quant_stage #(
  parameter int unsigned IN_W = 16,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned DITH_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_i,
  input  logic signed [IN_W-1:0]  scaled_i,
  input  logic [DITH_W-1:0]       dith_i,
  output logic                    vld_o,
  output logic signed [OUT_W-1:0] code_o
);
  localparam int unsigned SW = IN_W + 1;
  localparam logic signed [IN_W-1:0] POS_MAX = {1'b0, {(IN_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] NEG_MIN = {1'b1, {(IN_W-1){1'b0}}};

  logic signed [SW-1:0]   sum;
  logic signed [IN_W-1:0] sat;

  assign sum = $signed({scaled_i[IN_W-1], scaled_i})
             + $signed({{(SW-DITH_W){1'b0}}, dith_i});

  always_comb begin
    if (sum[SW-1] == sum[SW-2]) sat = sum[IN_W-1:0];
    else if (!sum[SW-1])        sat = POS_MAX;
    else                        sat = NEG_MIN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      code_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) code_o <= sat[IN_W-1 -: OUT_W];
    end
  end
endmodule

// File: rtl/amp_dither_scaler.sv
module amp_dither_scaler
  import amp_dither_pkg::*;
#(
  parameter int unsigned IN_W   = DEF_IN_W,
  parameter int unsigned AMP_W  = DEF_AMP_W,
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter int unsigned LFSR_W = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] TAPS = DEF_TAPS,
  parameter logic [LFSR_W-1:0] SEED = DEF_SEED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  input  logic [AMP_W-1:0] amp_word,
  input  logic             dither_en,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_code
);
  localparam int unsigned DROP_W = IN_W - OUT_W;
  localparam int unsigned DITH_W = DROP_W - 1;

  logic [LFSR_W-1:0]      lfsr_q;
  logic                   s1_valid;
  logic signed [IN_W-1:0] s1_scaled;
  logic [DITH_W-1:0]      s1_dith;
  logic signed [OUT_W-1:0] code_s;

  ad_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(in_valid), .state(lfsr_q)
  );

  ad_mul_stage #(.IN_W(IN_W), .AMP_W(AMP_W), .DITH_W(DITH_W)) u_mul (
    .clk(clk), .rst(rst), .vld_i(in_valid), .sample_i($signed(in_sample)),
    .amp_i(amp_word), .dith_i(lfsr_q[DITH_W-1:0]), .den_i(dither_en),
    .vld_o(s1_valid), .scaled_o(s1_scaled), .dith_o(s1_dith)
  );

  ad_quant_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .DITH_W(DITH_W)) u_quant (
    .clk(clk), .rst(rst), .vld_i(s1_valid), .scaled_i(s1_scaled),
    .dith_i(s1_dith), .vld_o(out_valid), .code_o(code_s)
  );

  assign out_code = code_s;
endmodule

// File: rtl/amp_dither_chk.sv
module amp_dither_chk #(
  parameter int unsigned IN_W = 16,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned LFSR_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [LFSR_W-1:0]      lfsr_q,
  input logic                   s1_valid,
  input logic signed [IN_W-1:0] s1_scaled,
  input logic                   out_valid,
  input logic [OUT_W-1:0]       out_code
);
  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(s1_valid)));
  // R4
  zero_amp_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_scaled == '0) |=> (out_code == '0));
  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
  // R6
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(lfsr_q));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_scaled[IN_W-1]) |=> !out_code[OUT_W-1]);
endmodule

bind amp_dither_scaler amp_dither_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .LFSR_W(LFSR_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .lfsr_q(lfsr_q),
  .s1_valid(s1_valid), .s1_scaled(s1_scaled),
  .out_valid(out_valid), .out_code(out_code)
);

// File: tb/amp_dither_scaler_tb_top.sv
module amp_dither_scaler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [15:0] amp_word = '0;
  logic dither_en = 1'b0;
  logic out_valid;
  logic [11:0] out_code;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [15:0] ref_st = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_dither_scaler dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .amp_word(amp_word), .dither_en(dither_en),
    .out_valid(out_valid), .out_code(out_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: expired, actual cycles %0d expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int model(int smp, int amp, bit den, logic [15:0] st);
    longint p, s, sum;
    p = longint'(smp) * longint'(amp);
    s = p >>> 16;
    sum = s + (den ? longint'(st[2:0]) : 0);
    if (sum > 32767) sum = 32767;
    if (sum < -32768) sum = -32768;
    return int'(sum >>> 4);
  endfunction

  function automatic logic [15:0] lfsr_step(logic [15:0] st);
    return st[0] ? ((st >> 1) ^ 16'hB400) : (st >> 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One sample; optional disturbance of amp/enable after capture (R9)
  task automatic one(string req, int smp, int amp, bit den, bit disturb);
    int exp;
    @(negedge clk);
    in_valid = 1; in_sample = 16'(smp); amp_word = 16'(amp); dither_en = den;
    exp = model(smp, amp, den, ref_st);
    ref_st = lfsr_step(ref_st);
    @(negedge clk);
    in_valid = 0;
    if (disturb) begin amp_word = ~amp_word; dither_en = ~dither_en; end
    check("R1 early valid", int'(out_valid), 0);
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check(req, int'($signed(out_code)), exp);
    @(negedge clk);
    check("R1 single pulse", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset code", int'(out_code), 0);
  endtask

  task automatic t_plain();
    one("R2 pos half gain", 1000, 16'h8000, 0, 0);
    one("R2 neg half gain", -1000, 16'h8000, 0, 0);
    one("R2 odd gain", 12345, 16'h1234, 0, 0);
    one("R2 neg odd gain", -23456, 16'hC001, 0, 0);
  endtask

  task automatic t_unity();
    one("R3 unity pos", 1000, 16'hFFFF, 0, 0);
    one("R3 unity neg", -777, 16'hFFFF, 0, 0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < 4; i++) one("R4 zero amp", 30000 - i * 20000, 0, 1, 0);
  endtask

  task automatic t_dither();
    for (int i = 0; i < 8; i++) one("R5 dither", 1000 + i * 3, 16'hFFFF, 1, 0);
  endtask

  task automatic t_stream();
    int exp[10];
    int k = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        if ((i - 2) % 3 != 2) begin
          check("R6 stream valid", int'(out_valid), 1);
          check("R6 stream code", int'($signed(out_code)), exp[k]);
          k++;
        end else check("R6 gap no valid", int'(out_valid), 0);
      end
      if (i < 12 && i % 3 != 2) begin
        in_valid = 1; in_sample = 16'(2000 + i * 5); amp_word = 16'hFFFF;
        dither_en = (i % 4 != 3);
        exp[(i / 3) * 2 + (i % 3)] = model(2000 + i * 5, 16'hFFFF, dither_en, ref_st);
        ref_st = lfsr_step(ref_st);
      end else in_valid = 0;
    end
    in_valid = 0;
  endtask

  task automatic t_sat();
    for (int i = 0; i < 6; i++) one("R7 saturate", 32767, 16'hFFFF, 1, 0);
    one("R8 neg full scale", -32768, 16'hFFFF, 1, 0);
    one("R8 neg full scale no dither", -32768, 16'hFFFF, 0, 0);
  endtask

  task automatic t_capture();
    one("R9 capture amp", 5000, 16'h4000, 0, 1);
    one("R9 capture dither", 1004, 16'hFFFF, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_plain();
    t_unity();
    t_zero();
    t_dither();
    t_stream();
    t_sat();
    t_capture();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule